// File: doc/BRIEF.md
# Serial Data Steering Adder

This block moves bit-serial two's-complement words from a bank of serial input lanes to a small set of serial output lanes. While a word travels, each output lane can add or subtract up to two further selected inputs to its base operand. The result leaves on the output lane in the same beats that carry the operands in. A three-operand sum therefore takes no more time than a plain copy. Words go least-significant bit first, so each carry moves forward in time through a carry flop.

Every input and output lane advances in lockstep under one valid/ready handshake. A beat transfers when `in_valid` and `out_ready` are both high. The block adds no storage on the data path: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. A stalled beat keeps its bit values, and the carries and the beat position stay unchanged until that beat transfers.

The block counts beats itself. The first transfer after reset is bit 0 of a word, and each word is `WORD_W` beats long. A command word is taken from `cmd` on the bit-0 beat of each word and holds until that word ends. An output lane may feed the input lane of another copy of the block, so copies can be chained.

Top module: `serial_steer_adder`

## Requirements
- R1: After reset no beat has transferred, the next transfer is bit 0 of a word (`out_first` high), and every bit of `ovf` is 0.
- R2: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. Data moves only on a beat where both `in_valid` and `out_ready` are high. While a beat is stalled, the beat position and the carries hold.
- R3: An output lane with both extra operands disabled copies its selected input. It puts bit k of the word out on the k-th beat of the frame, with bit 0 first.
- R4: A select code of `N_IN` or above selects a constant 0 operand.
- R5: With operand B enabled and not negated, the lane outputs A+B modulo 2^`WORD_W`.
- R6: With operand B enabled and negated, the lane outputs A-B in two's complement. The negation inverts B's bits and adds a carry-in of 1 at bit 0.
- R7: With operand C also enabled, the lane outputs A±B±C within the same `WORD_W` beats. C is negated when its negate flag is set.
- R8: Results outside the signed range wrap modulo 2^`WORD_W`.
- R9: `ovf[j]` updates in the cycle after the last beat of a word transfers. It is 1 exactly when the exact integer result of lane j falls outside [-2^(`WORD_W`-1), 2^(`WORD_W`-1)-1]. It holds until the next word ends.
- R10: `cmd` is read only on the bit-0 beat that transfers. Changes to `cmd` on any other beat have no effect on the word in flight.
- R11: `out_first` is high exactly at bit 0 and `out_last` exactly at bit `WORD_W`-1. The beat after a last beat is bit 0.
- R12: Output lanes are independent. Several lanes may select the same input in the same word.

Command layout: lane j uses bits `cmd[16*j+15:16*j]`. Within those 16 bits, [3:0] selects operand A, [7:4] selects operand B and [11:8] selects operand C. Bit 12 enables B, bit 13 negates B, bit 14 enables C and bit 15 negates C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present on all lanes |
| in_ready | output | 1 | Block accepts the beat |
| in_bits | input | N_IN (13) | One serial bit per input lane |
| cmd | input | N_OUT*16 (48) | Command word, read on bit-0 beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_bits | output | N_OUT (3) | One result bit per output lane |
| out_first | output | 1 | Current beat is bit 0 |
| out_last | output | 1 | Current beat is bit WORD_W-1 |
| ovf | output | N_OUT (3) | Per-lane overflow of the last finished word |

## Verification
A wrong carry flop shows up as a bad result bit. It appears on the beat after the broken carry should have applied, and it usually corrupts every higher bit of that word. A beat counter that drifts or moves during a stall moves `out_first` and `out_last` at once. It also makes the block read the command mid-word, which corrupts whole results and shows up within one frame. A wrong overflow path shows in `ovf` one cycle after the last beat. Corner words check that path: an intermediate sum that overflows and then cancels, and negation of the most negative value.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  // number of operands summed per output lane
  localparam int OPS_PER_LANE = 3;

  // per-lane control flags that follow the three selects in a lane command
  typedef struct packed {
    logic neg_c;
    logic use_c;
    logic neg_b;
    logic use_b;
  } lane_flags_t;

  localparam int FLAG_W = $bits(lane_flags_t);

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/ssa_beat_ctrl.sv
module ssa_beat_ctrl #(
  parameter int WORD_W = 20,
  parameter int CMD_W  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             first,
  output logic             last,
  output logic [CMD_W-1:0] cmd_eff
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] cmd_q;

  assign first   = (cnt_q == '0);
  assign last    = (cnt_q == LAST_POS);
  // bit-0 beat uses the live command; later beats use the captured one
  assign cmd_eff = first ? cmd_in : cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (last) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (adv && first) begin
      cmd_q <= cmd_in;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)); // R2

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && first) |=> $stable(cmd_q)); // R10

  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last) |=> first); // R11

  generate
    if (WORD_W > 1) begin : g_excl
      always_comb begin
        if (rst_n) begin
          AST_FIRST_NOT_LAST: assert (!(first && last)); // R11
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ssa_sel.sv
module ssa_sel #(
  parameter int N_IN  = 13,
  parameter int SEL_W = 4
) (
  input  logic [N_IN-1:0]  bits,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  logic [N_IN-1:0] hit;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_hit
      assign hit[i] = bits[i] & (sel == SEL_W'(i));
    end
  endgenerate

  // codes at or above N_IN match nothing and give a zero operand
  assign y = |hit;

endmodule

// File: rtl/ssa_serial_add.sv
module ssa_serial_add (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic first,
  input  logic x,
  input  logic y_raw,
  input  logic use_y,
  input  logic neg_y,
  output logic s,
  output logic y_eff,
  output logic co
);

  import ssa_pkg::*;

  logic carry_q;
  logic cin;

  assign y_eff = use_y & (y_raw ^ neg_y);
  // the carry-in at bit 0 is 1 only when the operand is negated
  assign cin   = first ? (use_y & neg_y) : carry_q;
  assign s     = x ^ y_eff ^ cin;
  assign co    = maj3(x, y_eff, cin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   carry_q <= 1'b0;
    else if (adv) carry_q <= co;
  end

  AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && first && !use_y) |=> (carry_q == 1'b0)); // R3

  AST_CARRY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(carry_q)); // R2

endmodule

// File: rtl/ssa_lane.sv
module ssa_lane #(
  parameter int N_IN  = 13,
  parameter int SEL_W = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   adv,
  input  logic                                   first,
  input  logic                                   last,
  input  logic [N_IN-1:0]                        bits,
  input  logic [ssa_pkg::OPS_PER_LANE*SEL_W+ssa_pkg::FLAG_W-1:0] ctl,
  output logic                                   out_bit,
  output logic                                   ovf
);

  import ssa_pkg::*;

  lane_flags_t            flags;
  logic [OPS_PER_LANE-1:0] op;

  assign flags = lane_flags_t'(ctl[OPS_PER_LANE*SEL_W +: FLAG_W]);

  generate
    for (genvar g = 0; g < OPS_PER_LANE; g++) begin : g_op
      ssa_sel #(.N_IN(N_IN), .SEL_W(SEL_W)) sel_i (
        .bits (bits),
        .sel  (ctl[g*SEL_W +: SEL_W]),
        .y    (op[g])
      );
    end
  endgenerate

  logic s1, yb, co1;
  logic s2, yc, co2;

  ssa_serial_add add_ab_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .first (first),
    .x     (op[0]),
    .y_raw (op[1]),
    .use_y (flags.use_b),
    .neg_y (flags.neg_b),
    .s     (s1),
    .y_eff (yb),
    .co    (co1)
  );

  ssa_serial_add add_c_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .first (first),
    .x     (s1),
    .y_raw (op[2]),
    .use_y (flags.use_c),
    .neg_y (flags.neg_c),
    .s     (s2),
    .y_eff (yc),
    .co    (co2)
  );

  assign out_bit = s2;

  // At the sign beat, extend both stages by two bits so the exact sum can be
  // compared against what fits in the word.
  logic s1_x1, s2_x1, c_x2, s2_x2, ovf_now, ovf_q;

  always_comb begin
    s1_x1   = op[0] ^ yb ^ co1;
    s2_x1   = s1_x1 ^ yc ^ co2;
    c_x2    = maj3(s1_x1, yc, co2);
    s2_x2   = s1_x1 ^ yc ^ c_x2;
    ovf_now = (s2_x2 != s2_x1) || (s2_x1 != s2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ovf_q <= 1'b0;
    else if (adv && last)  ovf_q <= ovf_now;
  end

  assign ovf = ovf_q;

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && last) |=> $stable(ovf_q)); // R9

  AST_PLAIN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last && !flags.use_b && !flags.use_c) |=> !ovf_q); // R9

endmodule

// File: rtl/serial_steer_adder.sv
module serial_steer_adder #(
  parameter int N_IN   = 13,
  parameter int N_OUT  = 3,
  parameter int WORD_W = 20,
  localparam int SEL_W  = (N_IN > 1) ? $clog2(N_IN + 1) : 1,
  localparam int LANE_W = ssa_pkg::OPS_PER_LANE*SEL_W + ssa_pkg::FLAG_W,
  localparam int CMD_W  = N_OUT*LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_IN-1:0]   in_bits,
  input  logic [CMD_W-1:0]  cmd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [N_OUT-1:0]  out_bits,
  output logic              out_first,
  output logic              out_last,
  output logic [N_OUT-1:0]  ovf
);

  logic             adv;
  logic             first, last;
  logic [CMD_W-1:0] cmd_eff;

  // lanes move in lockstep with no storage on the path
  assign adv       = in_valid && out_ready;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_first = first;
  assign out_last  = last;

  ssa_beat_ctrl #(.WORD_W(WORD_W), .CMD_W(CMD_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .cmd_in  (cmd),
    .first   (first),
    .last    (last),
    .cmd_eff (cmd_eff)
  );

  generate
    for (genvar j = 0; j < N_OUT; j++) begin : g_lane
      ssa_lane #(.N_IN(N_IN), .SEL_W(SEL_W)) lane_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .first   (first),
        .last    (last),
        .bits    (in_bits),
        .ctl     (cmd_eff[j*LANE_W +: LANE_W]),
        .out_bit (out_bits[j]),
        .ovf     (ovf[j])
      );
    end
  endgenerate

  AST_MARKS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) |=> ($stable(out_first) && $stable(out_last))); // R2

  AST_OVF_QUIET_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready && out_last) |=> $stable(ovf)); // R9

endmodule

// File: tb/serial_steer_adder_tb.sv
`timescale 1ns/1ps
module serial_steer_adder_tb_top;

  localparam int NI = 13;
  localparam int NO = 3;
  localparam int WW = 20;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [NI-1:0] in_bits = '0;
  logic [CW-1:0] cmd = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [NO-1:0] out_bits;
  logic          out_first;
  logic          out_last;
  logic [NO-1:0] ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [WW-1:0] w [NI];

  always #2.5 clk = ~clk;

  serial_steer_adder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .cmd(cmd), .out_valid(out_valid), .out_ready(out_ready),
    .out_bits(out_bits), .out_first(out_first), .out_last(out_last), .ovf(ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic longint opnd(input logic [3:0] s);
    longint v;
    if (s >= 4'(NI)) return 0;
    v = longint'($signed(w[s]));
    return v;
  endfunction

  function automatic longint lane_val(input logic [15:0] f);
    longint v;
    v = opnd(f[3:0]);
    if (f[12]) v = f[13] ? v - opnd(f[7:4]) : v + opnd(f[7:4]);
    if (f[14]) v = f[15] ? v - opnd(f[11:8]) : v + opnd(f[11:8]);
    return v;
  endfunction

  function automatic string lane_tag(input logic [15:0] f);
    if (f[3:0] >= 4'(NI) || (f[12] && f[7:4] >= 4'(NI)) || (f[14] && f[11:8] >= 4'(NI)))
      return "R4";
    if (f[14]) return "R7";
    if (f[12]) return f[13] ? "R6" : "R5";
    return "R3";
  endfunction

  // Runs one word frame; cmd is randomised on every non-zero beat (R10).
  task automatic run_frame(input logic [CW-1:0] c, input int stall_pct, input string extra);
    int k;
    int hs_err;
    int mk_err;
    logic [WW-1:0] got [NO];
    k = 0; hs_err = 0; mk_err = 0;
    while (k < WW) begin
      @(negedge clk);
      in_valid  = (($urandom % 100) >= stall_pct);
      out_ready = (($urandom % 100) >= stall_pct);
      for (int i = 0; i < NI; i++) in_bits[i] = w[i][k];
      cmd = (k == 0) ? c : {$urandom(), $urandom()};
      #1;
      if (out_valid !== in_valid || in_ready !== out_ready) hs_err++;
      if (in_valid && out_ready) begin
        if (out_first !== (k == 0) || out_last !== (k == WW-1)) mk_err++;
        for (int j = 0; j < NO; j++) got[j][k] = out_bits[j];
        k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R2 handshake mismatches", hs_err, 0);
    check("R11 frame marker mismatches", mk_err, 0);
    for (int j = 0; j < NO; j++) begin
      logic [15:0] f;
      longint v;
      logic exp_ovf;
      f = c[16*j +: 16];
      v = lane_val(f);
      exp_ovf = (v > 524287) || (v < -524288);
      check({lane_tag(f), " R8 R10 R12 lane word ", extra}, longint'(got[j]), longint'(v[WW-1:0]));
      check({"R9 lane ovf ", extra}, longint'(ovf[j]), longint'(exp_ovf));
    end
  endtask

  function automatic logic [15:0] lf(input int a, input int b, input int c2,
                                     input bit ub, input bit nb, input bit uc, input bit nc);
    return {nc, uc, nb, ub, 4'(c2), 4'(b), 4'(a)};
  endfunction

  initial begin
    for (int i = 0; i < NI; i++) w[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 ovf after reset", longint'(ovf), 0);
    check("R1 out_first after reset", longint'(out_first), 1);
    check("R1 out_valid idle", longint'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    check("R1 out_first after release", longint'(out_first), 1);

    void'($urandom(32'd20240611));

    // plain copies, no stalls
    for (int i = 0; i < NI; i++) w[i] = 20'(32'h1357 * (i + 1) + 32'h80001 * i);
    run_frame({lf(5,0,0,0,0,0,0), lf(12,0,0,0,0,0,0), lf(0,0,0,0,0,0,0)}, 0, "copy");

    // out-of-range selects give zero (R4)
    run_frame({lf(13,14,15,1,0,1,0), lf(15,0,0,0,0,0,0), lf(3,13,14,1,1,1,1)}, 0, "R4 zero-select");

    // overflow and wrap corners (R8, R9)
    w[0] = 20'h7FFFF; w[1] = 20'h00001; w[2] = 20'h80000; w[3] = 20'h00000;
    run_frame({lf(0,1,0,1,0,0,0), lf(3,2,0,1,1,0,0), lf(2,2,2,1,0,1,0)}, 10, "wrap");
    // intermediate overflow that cancels; negate most negative; all three same input
    run_frame({lf(0,0,0,1,0,1,1), lf(2,2,3,1,1,0,0), lf(2,0,1,1,1,1,1)}, 10, "cancel");
    w[4] = 20'h12345;
    run_frame({lf(4,0,0,0,0,0,0), lf(4,4,0,1,0,0,0), lf(4,4,4,1,1,1,1)}, 0, "R12 shared");

    // heavy back-pressure (R2)
    for (int i = 0; i < NI; i++) w[i] = 20'($urandom());
    run_frame({$urandom(), $urandom()}, 80, "R2 stall");

    // random frames
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NI; i++) begin
        case ($urandom % 8)
          0: w[i] = 20'h7FFFF;
          1: w[i] = 20'h80000;
          default: w[i] = 20'($urandom());
        endcase
      end
      run_frame({$urandom(), $urandom()}, $urandom % 40, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule